// File: doc/BRIEF.md
# Frame-Aligned Serial Audio Transmitter

This block is the transmit half of a two-channel serial audio port. It runs on the bit clock and generates a frame-sync signal that never stops. Each frame holds two 16-bit slots, and frame-sync is high for the first (left) slot. Parallel samples arrive over a ready/valid handshake and leave the block MSB first on a single serial line. Each word starts one bit clock after its slot begins.

Software does not drive the transmitter enable straight into the shifter. In latched mode, the enable passes through a two-stage setup pipeline and is captured once per frame, just before frame-sync rises. Transmission therefore starts and stops only on frame boundaries. Three cases bypass this:

- Direct mode uses the enable as it is.
- Gated-clock mode forces direct use of the enable.
- The quick-start option switches the transmitter on at once. Switching it off still waits for the frame capture. The option applies only when the transmitter is not slaved to an active receiver.

A synchronous soft reset returns everything to the idle state.

Top module: `ftx_serial_tx`

## Requirements
- R1: A frame is 32 bit clocks, indexed 0 to 31 from the cycle after any reset. `fs_out` is high for indexes 0..15 and low for 16..31, whether or not the transmitter is enabled.
- R2: In latched mode (`latch_mode`=1, `gated_mode`=0, quick start not in effect), `tx_active` changes only in the cycle where the frame index becomes 0.
- R3: In latched mode, the value `tx_active` takes at index 0 is the `tx_en_sw` value present during index 29 of the previous frame. A change made during index 30 or 31 takes effect one frame later.
- R4: With `latch_mode`=0, `tx_active` equals `tx_en_sw` in the same cycle.
- R5: With `gated_mode`=1, `latch_mode` is ignored and `tx_active` equals `tx_en_sw` in the same cycle.
- R6: Quick start is in effect when `latch_mode`=1, `fclk_dis`=1 and (`sync_mode`=0 or `rx_en`=0). In that case, `tx_en_sw` high makes `tx_active` high in the next cycle. A drop of `tx_en_sw` still follows R2 and R3. With `sync_mode`=1 and `rx_en`=1, `fclk_dis` has no effect.
- R7: At frame index 0 or 16 with `tx_active` high, a 16-bit word is loaded. Its bit 15 appears on `sd_out` in the next cycle, followed by bits 14 down to 0 on consecutive cycles.
- R8: `smp_ready` is high for exactly the cycle at index 0 or 16 in which `tx_active` is high. The word on `smp_data` is consumed there if `smp_valid` is high.
- R9: If `smp_ready` is high while `smp_valid` is low, the slot transmits all zeros and `underrun` is set. `underrun` stays set until a reset.
- R10: In any cycle after one with `tx_active` low, `sd_out` is 0. With `tx_active` low, `smp_ready` stays 0.
- R11: `soft_rst`=1 forces `tx_active` and `smp_ready` to 0 in that cycle. At the next clock edge it clears the frame index, the setup pipeline, the captured enable, the shifter and `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset of the whole block |
| tx_en_sw | input | 1 | Software transmit enable |
| latch_mode | input | 1 | 1: capture enable once per frame; 0: use it directly |
| gated_mode | input | 1 | Gated-clock mode; forces direct enable |
| fclk_dis | input | 1 | Quick-start option (immediate turn-on) |
| sync_mode | input | 1 | Transmitter slaved to receiver timing |
| rx_en | input | 1 | Receiver enable |
| smp_data | input | 16 | Parallel sample |
| smp_valid | input | 1 | Sample available |
| smp_ready | output | 1 | Sample taken this cycle |
| fs_out | output | 1 | Frame sync |
| sd_out | output | 1 | Serial data |
| tx_active | output | 1 | Effective transmit enable |
| underrun | output | 1 | Sticky missing-sample flag |

## Verification
Two events can land on the same clock edge: the frame capture of the delayed enable at index 31, and a fresh quick-start request or a fresh software toggle. The bench raises and drops `tx_en_sw` at indexes 29, 30, 3, 7 and 12. It does this in latched, direct, gated and quick-start modes, and with quick start blocked by an active receiver. A behavioural model keeps a queue of past enable values and predicts `tx_active`, `smp_ready` and every serial bit. The bench compares the model with the block every cycle, and also makes directed checks at the exact index where a start or stop is due.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    // How the software enable reaches the transmitter
    typedef struct packed {
        logic direct;   // enable used as it is
        logic fast;     // immediate turn-on, frame-aligned turn-off
    } en_route_t;

    function automatic en_route_t route_enable(
        input logic latch_mode,
        input logic gated_mode,
        input logic fclk_dis,
        input logic sync_mode,
        input logic rx_en
    );
        en_route_t r;
        r.direct = gated_mode | ~latch_mode;
        r.fast   = ~r.direct & fclk_dis & (~sync_mode | ~rx_en);
        return r;
    endfunction

endpackage

// File: rtl/ftx_frame_gen.sv
module ftx_frame_gen #(
    parameter int SLOT_W    = 16,
    parameter int NUM_SLOTS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    output logic fs,
    output logic slot_start,
    output logic frame_last
);
    localparam int FRAME_W   = SLOT_W * NUM_SLOTS;
    localparam int CNT_W     = $clog2(FRAME_W);
    localparam int SLOT_BITS = $clog2(SLOT_W);

    typedef struct packed {
        logic [CNT_W-1:0] idx;
    } frm_state_t;

    frm_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        frame_last = (st_q.idx == CNT_W'(FRAME_W - 1));
        slot_start = (st_q.idx[SLOT_BITS-1:0] == '0);
        fs         = (st_q.idx < CNT_W'(SLOT_W));
        if (soft_rst)        st_d.idx = '0;
        else if (frame_last) st_d.idx = '0;
        else                 st_d.idx = st_q.idx + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ftx_en_ctrl.sv
module ftx_en_ctrl
    import ftx_pkg::*;
#(
    parameter int SETUP_STAGES = 2  // at least 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic tx_en_sw,
    input  logic latch_mode,
    input  logic gated_mode,
    input  logic fclk_dis,
    input  logic sync_mode,
    input  logic rx_en,
    input  logic frame_last,
    output logic en_now
);
    typedef struct packed {
        logic [SETUP_STAGES-1:0] pipe;  // delayed enable samples
        logic                    held;  // frame-captured enable
    } en_state_t;

    en_state_t st_d, st_q;
    en_route_t route;
    logic      oldest;
    logic      kick;

    always_comb begin
        route  = route_enable(latch_mode, gated_mode, fclk_dis, sync_mode, rx_en);
        oldest = st_q.pipe[SETUP_STAGES-1];
        kick   = route.fast & tx_en_sw;
        st_d   = st_q;
        st_d.pipe = {st_q.pipe[SETUP_STAGES-2:0], tx_en_sw};
        if (frame_last) st_d.held = oldest | kick;
        else            st_d.held = st_q.held | kick;
        if (soft_rst) st_d = '0;

        if (soft_rst)          en_now = 1'b0;
        else if (route.direct) en_now = tx_en_sw;
        else                   en_now = st_q.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter #(
    parameter int SLOT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              en_now,
    input  logic              slot_start,
    input  logic [SLOT_W-1:0] smp_data,
    input  logic              smp_valid,
    output logic              smp_ready,
    output logic              sd_out,
    output logic              underrun
);
    typedef struct packed {
        logic [SLOT_W-1:0] sh;
        logic              sd;
        logic              und;
    } sh_state_t;

    sh_state_t         st_d, st_q;
    logic [SLOT_W-1:0] word;

    always_comb begin
        st_d      = st_q;
        smp_ready = en_now & slot_start;
        word      = smp_valid ? smp_data : '0;
        if (!en_now) begin
            st_d.sh = '0;
            st_d.sd = 1'b0;
        end else if (slot_start) begin
            st_d.sd  = word[SLOT_W-1];
            st_d.sh  = {word[SLOT_W-2:0], 1'b0};
            st_d.und = st_q.und | ~smp_valid;
        end else begin
            st_d.sd = st_q.sh[SLOT_W-1];
            st_d.sh = {st_q.sh[SLOT_W-2:0], 1'b0};
        end
        if (soft_rst) st_d = '0;
        sd_out   = st_q.sd;
        underrun = st_q.und;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ftx_serial_tx.sv
module ftx_serial_tx #(
    parameter int SLOT_W       = 16,
    parameter int NUM_SLOTS    = 2,
    parameter int SETUP_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tx_en_sw,
    input  logic              latch_mode,
    input  logic              gated_mode,
    input  logic              fclk_dis,
    input  logic              sync_mode,
    input  logic              rx_en,
    input  logic [SLOT_W-1:0] smp_data,
    input  logic              smp_valid,
    output logic              smp_ready,
    output logic              fs_out,
    output logic              sd_out,
    output logic              tx_active,
    output logic              underrun
);
    logic slot_start;
    logic frame_last;
    logic en_now;

    ftx_frame_gen #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_frame (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .fs(fs_out), .slot_start(slot_start), .frame_last(frame_last)
    );

    ftx_en_ctrl #(.SETUP_STAGES(SETUP_STAGES)) u_en (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_en_sw(tx_en_sw),
        .latch_mode(latch_mode), .gated_mode(gated_mode), .fclk_dis(fclk_dis),
        .sync_mode(sync_mode), .rx_en(rx_en), .frame_last(frame_last),
        .en_now(en_now)
    );

    ftx_shifter #(.SLOT_W(SLOT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .en_now(en_now),
        .slot_start(slot_start), .smp_data(smp_data), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .sd_out(sd_out), .underrun(underrun)
    );

    assign tx_active = en_now;
endmodule

// File: rtl/ftx_serial_tx_chk.sv
module ftx_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic latch_mode,
    input logic gated_mode,
    input logic fclk_dis,
    input logic sync_mode,
    input logic rx_en,
    input logic smp_ready,
    input logic fs_out,
    input logic sd_out,
    input logic tx_active,
    input logic underrun
);
    logic framed;
    assign framed = latch_mode & ~gated_mode & ~(fclk_dis & (~sync_mode | ~rx_en));

    AST_READY_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> tx_active);  // R8

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |=> !sd_out);  // R10

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !soft_rst) |=> underrun);  // R9

    AST_FRAME_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (framed && $past(framed) && !soft_rst && !$past(soft_rst) && !$rose(fs_out))
            |-> $stable(tx_active));  // R2

    AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!underrun && fs_out && !sd_out));  // R11

    AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (!tx_active && !smp_ready));  // R11
endmodule

bind ftx_serial_tx ftx_serial_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .latch_mode(latch_mode),
    .gated_mode(gated_mode), .fclk_dis(fclk_dis), .sync_mode(sync_mode),
    .rx_en(rx_en), .smp_ready(smp_ready), .fs_out(fs_out), .sd_out(sd_out),
    .tx_active(tx_active), .underrun(underrun)
);

// File: tb/test_ftx_serial_tx.sv
module test_ftx_serial_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        tx_en_sw = 1'b0;
    logic        latch_mode = 1'b1;
    logic        gated_mode = 1'b0;
    logic        fclk_dis = 1'b0;
    logic        sync_mode = 1'b0;
    logic        rx_en = 1'b0;
    logic [15:0] smp_data = 16'hA5C3;
    logic        smp_valid = 1'b1;
    logic        smp_ready, fs_out, sd_out, tx_active, underrun;

    int    errors = 0;
    int    checks = 0;
    bit    started = 0;
    string cur_tag = "R2";

    // reference model state
    int          m_cnt = 0;
    bit          m_lat = 0;
    bit          m_hist[$];
    logic [15:0] m_sh = '0;
    bit          m_sd = 0;
    bit          m_und = 0;
    bit          m_pop = 0;

    always #5 clk = ~clk;

    ftx_serial_tx i_ftx_serial_tx (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_en_sw(tx_en_sw),
        .latch_mode(latch_mode), .gated_mode(gated_mode), .fclk_dis(fclk_dis),
        .sync_mode(sync_mode), .rx_en(rx_en), .smp_data(smp_data),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .fs_out(fs_out),
        .sd_out(sd_out), .tx_active(tx_active), .underrun(underrun)
    );

    function automatic bit exp_en();
        if (soft_rst) return 1'b0;
        if (gated_mode || !latch_mode) return tx_en_sw;
        return m_lat;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at t=%0t idx=%0d: actual=%b expected=%b", tag, $time, m_cnt, act, exp);
        end
    endtask

    // model update on each edge
    always @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            m_cnt = 0; m_lat = 0; m_hist = '{1'b0, 1'b0};
            m_sh = '0; m_sd = 0; m_und = 0; m_pop = 0;
        end else begin
            bit en, fast, s2;
            logic [15:0] w;
            en   = exp_en();
            fast = latch_mode && !gated_mode && fclk_dis && (!sync_mode || !rx_en);
            s2   = m_hist.pop_front();
            m_hist.push_back(tx_en_sw);
            m_pop = 0;
            if (!en) begin
                m_sh = '0; m_sd = 0;
            end else if (m_cnt % 16 == 0) begin
                if (smp_valid) begin w = smp_data; m_pop = 1; end
                else begin w = '0; m_und = 1; end
                m_sd = w[15];
                m_sh = w << 1;
            end else begin
                m_sd = m_sh[15];
                m_sh = m_sh << 1;
            end
            if (m_cnt == 31) m_lat = s2 || (fast && tx_en_sw);
            else             m_lat = m_lat || (fast && tx_en_sw);
            m_cnt = (m_cnt + 1) % 32;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && started) begin
            chk(fs_out, m_cnt < 16, "R1");
            chk(tx_active, exp_en(), cur_tag);
            chk(smp_ready, exp_en() && (m_cnt % 16 == 0), "R8");
            chk(sd_out, m_sd, "R7/R10");
            chk(underrun, m_und, "R9");
            #1;
            if (m_pop) smp_data = {smp_data[14:0], smp_data[15] ^ smp_data[13] ^ smp_data[12] ^ smp_data[10]} + 16'h0101;
        end
    end

    task automatic wait_idx(input int k);
        do @(negedge clk); while (m_cnt != k);
        #1;
    endtask

    task automatic scn(input bit lm, input bit gm, input bit fd, input bit sm, input bit re, input string tag);
        @(negedge clk); #1;
        soft_rst = 1; tx_en_sw = 0;
        latch_mode = lm; gated_mode = gm; fclk_dis = fd; sync_mode = sm; rx_en = re;
        @(negedge clk); #1;
        soft_rst = 0; cur_tag = tag;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1; started = 1;
        @(negedge clk); #1;
        chk(tx_active, 0, "R11"); chk(underrun, 0, "R11"); chk(fs_out, 1, "R1");

        // latched: rise at 29 taken, drop at 30 delayed one frame
        scn(1, 0, 0, 0, 0, "R2");
        wait_idx(29); tx_en_sw = 1;
        wait_idx(0);  chk(tx_active, 1, "R3");
        repeat (70) @(negedge clk);
        wait_idx(30); tx_en_sw = 0;
        wait_idx(0);  chk(tx_active, 1, "R3");
        wait_idx(0);  chk(tx_active, 0, "R3");

        // latched: rise at 30 waits a frame, mid-frame drop waits for boundary
        scn(1, 0, 0, 0, 0, "R2");
        wait_idx(30); tx_en_sw = 1;
        wait_idx(0);  chk(tx_active, 0, "R3");
        wait_idx(0);  chk(tx_active, 1, "R3");
        wait_idx(10); tx_en_sw = 0;
        wait_idx(20); chk(tx_active, 1, "R2");
        wait_idx(0);  chk(tx_active, 0, "R2");

        // direct
        scn(0, 0, 0, 0, 0, "R4");
        wait_idx(5); tx_en_sw = 1; #1 chk(tx_active, 1, "R4");
        repeat (70) @(negedge clk);
        wait_idx(9); tx_en_sw = 0; #1 chk(tx_active, 0, "R4");

        // gated overrides latch mode
        scn(1, 1, 0, 0, 0, "R5");
        wait_idx(3); tx_en_sw = 1; #1 chk(tx_active, 1, "R5");
        repeat (50) @(negedge clk);
        wait_idx(22); tx_en_sw = 0; #1 chk(tx_active, 0, "R5");

        // quick start, async
        scn(1, 0, 1, 0, 0, "R6");
        wait_idx(7); tx_en_sw = 1;
        wait_idx(8); chk(tx_active, 1, "R6");
        repeat (60) @(negedge clk);
        wait_idx(3);  tx_en_sw = 0;
        wait_idx(20); chk(tx_active, 1, "R6");
        wait_idx(0);  chk(tx_active, 0, "R6");

        // quick start, sync with receiver off
        scn(1, 0, 1, 1, 0, "R6");
        wait_idx(12); tx_en_sw = 1;
        wait_idx(13); chk(tx_active, 1, "R6");
        repeat (40) @(negedge clk);

        // quick start blocked by active receiver in sync mode
        scn(1, 0, 1, 1, 1, "R6");
        wait_idx(7); tx_en_sw = 1;
        wait_idx(8); chk(tx_active, 0, "R6");
        wait_idx(0); chk(tx_active, 1, "R6");
        repeat (40) @(negedge clk);

        // underrun
        scn(1, 0, 0, 0, 0, "R2");
        smp_valid = 0;
        wait_idx(20); tx_en_sw = 1;
        wait_idx(1);  chk(underrun, 1, "R9"); chk(sd_out, 0, "R9");
        smp_valid = 1;
        repeat (64) @(negedge clk);
        chk(underrun, 1, "R9");

        // soft reset mid-run
        @(negedge clk); #1 soft_rst = 1; cur_tag = "R11";
        #1 chk(tx_active, 0, "R11"); chk(smp_ready, 0, "R11");
        @(negedge clk); #1 soft_rst = 0;
        chk(underrun, 0, "R11"); chk(fs_out, 1, "R11"); chk(tx_active, 0, "R11");
        wait_idx(0); chk(tx_active, 1, "R11");
        repeat (40) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule